// File: doc/BRIEF.md
# Stereo Echo FIR Unit

This block adds an echo to a stereo mix. On every audio frame strobe it reads the oldest stereo frame from a ring buffer in shared byte-wide memory. It then passes that frame through an 8-tap FIR filter with signed coefficients, one filter per channel. The filtered value scaled by a separate signed volume for each channel becomes the echo output. The filtered value scaled by a signed feedback gain is added to the incoming mix and written back into the same slot. The ring buffer occupies a region of the memory set by a page register and a length register. The write path can be switched off while the read and filter path keeps running.

The block drives a simple synchronous memory port: one byte per cycle, with read data returned the cycle after the read request. It assumes that it owns the port during a frame and that frame strobes are at least 10 clock cycles apart. A frame takes 10 cycles from strobe to the pointer update. The configuration inputs are expected to stay stable while a frame is in progress.

Top module: `stereo_echo_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `echo_l`, `echo_r` and `echo_valid` are 0. Neither memory enable is asserted until a strobe arrives. All FIR history taps hold zero.
- R2: A strobe seen in idle starts a frame. The frame issues four reads on consecutive cycles at addresses frame address +0, +1, +2 and +3. These bytes are left low, left high, right low and right high, each 16-bit word being little-endian. Four writes of the new frame to the same four addresses follow, in the same byte order. A strobe that arrives while a frame is in progress is ignored.
- R3: The frame address is `buf_page`×256 plus a pointer offset. The offset starts at 0 and grows by 4 after each frame. It returns to 0 when the next value would reach the buffer length. The length is `buf_delay`×2048 bytes, or 4 bytes when `buf_delay` is 0.
- R4: Each channel's filter output is the sum over taps k=0..7 of coefficient k (signed byte `coef_taps[8k+7:8k]`) times history sample k. History sample 0 is the word read in the current frame and sample k is the one read k frames earlier. The sum is arithmetically shifted right by 7 and then saturated.
- R5: Coefficients 127,0,0,0,0,0,0,0 act as a pass-through: the filter output is the current read word times 127, shifted right by 7.
- R6: `echo_l` is the left filter output times signed `vol_l`, shifted right by 7 and saturated. `echo_r` is formed the same way with `vol_r`. Both update together with a one-cycle `echo_valid` pulse, 6 cycles after the strobe is sampled, and hold at all other times.
- R7: The word written back is the latched mix input plus (filter output × signed `fb_gain`) shifted right by 7, saturated.
- R8: While `echo_wr_dis` is high no memory write occurs and the buffer keeps its contents. The reads, the filter, the outputs and the pointer advance continue.
- R9: Every saturation clamps to the range −32768..32767.
- R10: With feedback 0, a word written in frame n is read back in frame n + length/4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_strobe | input | 1 | One-cycle audio frame strobe |
| mix_l | input | 16 | Signed left input mix |
| mix_r | input | 16 | Signed right input mix |
| buf_page | input | 8 | Ring buffer base in 256-byte pages |
| buf_delay | input | 4 | Ring buffer length in 2048-byte units |
| fb_gain | input | 8 | Signed feedback gain |
| vol_l | input | 8 | Signed left echo volume |
| vol_r | input | 8 | Signed right echo volume |
| coef_taps | input | 64 | Eight signed 8-bit FIR coefficients, tap k at bits 8k+7:8k |
| echo_wr_dis | input | 1 | Suppresses buffer writes |
| mem_addr | output | 16 | Memory byte address |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid one cycle after the request |
| echo_l | output | 16 | Signed left echo output |
| echo_r | output | 16 | Signed right echo output |
| echo_valid | output | 1 | Pulses when the echo outputs update |

## Verification
A corrupted FIR history tap shows up on `echo_l`/`echo_r` at the next `echo_valid` pulse. It keeps distorting the outputs for up to seven further frames as the bad word moves down the taps. A wrong pointer offset or wrap shows at once on `mem_addr` in the same frame. A late wrap is caught one frame later as an access outside the buffer region. A skipped or early wrap appears as a stale echo exactly one buffer length later. Byte-order or write-data faults are visible in the memory on the frame's last write cycle. They also distort the echo when that slot is read again.

// File: rtl/echo_pkg.sv
// Shared definitions for the stereo echo unit.
// Assumes 16-bit samples stored as two bytes per channel.
package echo_pkg;
    localparam int FRAME_BYTES = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD1,
        ST_RD2,
        ST_RD3,
        ST_LATCH,
        ST_CALC,
        ST_WR0,
        ST_WR1,
        ST_WR2,
        ST_WR3
    } echo_state_e;
endpackage

// File: rtl/echo_ptr.sv
// Ring buffer pointer: keeps the byte offset of the current frame inside
// the echo region and forms the frame base address from the page register.
// Assumes the length never exceeds the address space above the base.
module echo_ptr #(
    parameter int AW         = 16,
    parameter int DLYW       = 4,
    parameter int UNIT_BYTES = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-9:0]     page,
    input  logic [DLYW-1:0]   dly,
    input  logic              adv,
    output logic [AW-1:0]     frame_addr
);
    localparam int FB = echo_pkg::FRAME_BYTES;

    logic [AW-1:0] offset;
    logic [AW-1:0] len_bytes;
    logic [AW-1:0] next_off;

    // Buffer length in bytes and the candidate next offset.
    always_comb begin
        len_bytes = (dly == '0) ? AW'(FB) : AW'(dly) * AW'(UNIT_BYTES);
        next_off  = offset + AW'(FB);
    end

    // Offset register: steps one frame, wraps to zero at the end of the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset <= '0;
        end else if (adv) begin
            offset <= (next_off >= len_bytes) ? '0 : next_off;
        end
    end

    // Frame base address = page * 256 + offset.
    assign frame_addr = {page, 8'h00} + offset;

    // R3
    ptr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        offset[1:0] == 2'b00);

    // R3
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(offset));
endmodule

// File: rtl/echo_fir.sv
// One channel of the echo FIR: a shift register of past buffer words and
// a signed multiply-accumulate over all taps, scaled by 2^-(CW-1) and
// saturated to the sample width. Tap 0 multiplies the newest word.
module echo_fir #(
    parameter int DW   = 16,
    parameter int CW   = 8,
    parameter int TAPS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic signed [DW-1:0] sample_in,
    input  logic [TAPS*CW-1:0]   coef_taps,
    output logic signed [DW-1:0] fir_out
);
    localparam int PW    = DW + CW;
    localparam int ACCW  = PW + $clog2(TAPS);
    localparam int SHIFT = CW - 1;
    localparam logic signed [ACCW-1:0] MAXV = ACCW'(2**(DW-1) - 1);
    localparam logic signed [ACCW-1:0] MINV = ~MAXV;

    logic signed [DW-1:0]   hist [TAPS];
    logic signed [PW-1:0]   prod [TAPS];
    logic signed [ACCW-1:0] acc;
    logic signed [ACCW-1:0] scaled;

    // Clamp a wide accumulator value to the sample range.
    function automatic logic signed [DW-1:0] clip(input logic signed [ACCW-1:0] v);
        if (v > MAXV)      return MAXV[DW-1:0];
        else if (v < MINV) return MINV[DW-1:0];
        else               return v[DW-1:0];
    endfunction

    // History shift register: newest word enters tap 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) hist[k] <= '0;
        end else if (shift_en) begin
            hist[0] <= sample_in;
            for (int k = 1; k < TAPS; k++) hist[k] <= hist[k-1];
        end
    end

    // One signed multiplier per tap.
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        assign prod[k] = PW'(hist[k]) * PW'($signed(coef_taps[k*CW +: CW]));
    end

    // Accumulate products, rescale and saturate.
    always_comb begin
        acc = '0;
        for (int k = 0; k < TAPS; k++) acc = acc + ACCW'(prod[k]);
        scaled  = acc >>> SHIFT;
        fir_out = clip(scaled);
    end
endmodule

// File: rtl/echo_scale.sv
// Per-channel gain stage: forms the echo output (filter x volume) and the
// buffer write word (input + filter x feedback), both rescaled by
// 2^-(CW-1) and saturated. Purely combinational.
module echo_scale #(
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic signed [DW-1:0] fir_in,
    input  logic signed [DW-1:0] in_mix,
    input  logic signed [CW-1:0] vol,
    input  logic signed [CW-1:0] fb,
    output logic signed [DW-1:0] echo_val,
    output logic signed [DW-1:0] wr_val
);
    localparam int W     = DW + CW + 1;
    localparam int SHIFT = CW - 1;
    localparam logic signed [W-1:0] MAXV = W'(2**(DW-1) - 1);
    localparam logic signed [W-1:0] MINV = ~MAXV;

    logic signed [W-1:0] vprod, vsh, fprod, fsh, wsum;

    // Clamp to the sample range.
    function automatic logic signed [DW-1:0] clip(input logic signed [W-1:0] v);
        if (v > MAXV)      return MAXV[DW-1:0];
        else if (v < MINV) return MINV[DW-1:0];
        else               return v[DW-1:0];
    endfunction

    // Volume and feedback products with rescale and saturation.
    always_comb begin
        vprod    = W'(fir_in) * W'(vol);
        vsh      = vprod >>> SHIFT;
        echo_val = clip(vsh);
        fprod    = W'(fir_in) * W'(fb);
        fsh      = fprod >>> SHIFT;
        wsum     = W'(in_mix) + fsh;
        wr_val   = clip(wsum);
    end
endmodule

// File: rtl/stereo_echo_unit.sv
// Stereo echo unit top: sequences one frame per strobe over a byte-wide
// synchronous memory (read latency one cycle). It reads the oldest frame,
// filters it, registers the echo outputs and writes input + feedback back
// to the same slot. Assumes DW = 16 (two bytes per channel), that strobes
// are at least 10 cycles apart and that configuration is stable within a frame.
module stereo_echo_unit #(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int CW         = 8,
    parameter int TAPS       = 8,
    parameter int DLYW       = 4,
    parameter int UNIT_BYTES = 2048
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_strobe,
    input  logic signed [DW-1:0] mix_l,
    input  logic signed [DW-1:0] mix_r,
    input  logic [AW-9:0]        buf_page,
    input  logic [DLYW-1:0]      buf_delay,
    input  logic signed [CW-1:0] fb_gain,
    input  logic signed [CW-1:0] vol_l,
    input  logic signed [CW-1:0] vol_r,
    input  logic [TAPS*CW-1:0]   coef_taps,
    input  logic                 echo_wr_dis,
    output logic [AW-1:0]        mem_addr,
    output logic                 mem_rd_en,
    output logic                 mem_wr_en,
    output logic [7:0]           mem_wdata,
    input  logic [7:0]           mem_rdata,
    output logic signed [DW-1:0] echo_l,
    output logic signed [DW-1:0] echo_r,
    output logic                 echo_valid
);
    import echo_pkg::*;

    localparam int NCH = 2;

    echo_state_e          state;
    logic [7:0]           l_lo, l_hi, r_lo;
    logic [1:0]           byte_idx;
    logic                 adv;
    logic                 shift_en;
    logic [AW-1:0]        frame_addr;
    logic signed [DW-1:0] in_q     [NCH];
    logic signed [DW-1:0] wr_q     [NCH];
    logic signed [DW-1:0] mix_in   [NCH];
    logic signed [CW-1:0] vol_sel  [NCH];
    logic signed [DW-1:0] fir_new  [NCH];
    logic signed [DW-1:0] fir_out  [NCH];
    logic signed [DW-1:0] echo_val [NCH];
    logic signed [DW-1:0] wr_val   [NCH];

    // Channel views of the input ports and of the assembled read words.
    always_comb begin
        mix_in[0]  = mix_l;
        mix_in[1]  = mix_r;
        vol_sel[0] = vol_l;
        vol_sel[1] = vol_r;
        fir_new[0] = {l_hi, l_lo};
        fir_new[1] = {mem_rdata, r_lo};
        shift_en   = (state == ST_LATCH);
    end

    echo_ptr #(
        .AW(AW), .DLYW(DLYW), .UNIT_BYTES(UNIT_BYTES)
    ) u_ptr (
        .clk(clk), .rst_n(rst_n), .page(buf_page), .dly(buf_delay),
        .adv(adv), .frame_addr(frame_addr)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        echo_fir #(.DW(DW), .CW(CW), .TAPS(TAPS)) u_fir (
            .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
            .sample_in(fir_new[ch]), .coef_taps(coef_taps),
            .fir_out(fir_out[ch])
        );
        echo_scale #(.DW(DW), .CW(CW)) u_scale (
            .fir_in(fir_out[ch]), .in_mix(in_q[ch]), .vol(vol_sel[ch]),
            .fb(fb_gain), .echo_val(echo_val[ch]), .wr_val(wr_val[ch])
        );
    end

    // Frame sequencer: state advance and capture of read bytes and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            l_lo    <= '0;
            l_hi    <= '0;
            r_lo    <= '0;
            in_q[0] <= '0;
            in_q[1] <= '0;
            wr_q[0] <= '0;
            wr_q[1] <= '0;
            echo_l  <= '0;
            echo_r  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (frame_strobe) begin
                    in_q[0] <= mix_in[0];
                    in_q[1] <= mix_in[1];
                    state   <= ST_RD1;
                end
                ST_RD1:   begin l_lo <= mem_rdata; state <= ST_RD2;   end
                ST_RD2:   begin l_hi <= mem_rdata; state <= ST_RD3;   end
                ST_RD3:   begin r_lo <= mem_rdata; state <= ST_LATCH; end
                ST_LATCH: state <= ST_CALC;
                ST_CALC: begin
                    echo_l  <= echo_val[0];
                    echo_r  <= echo_val[1];
                    wr_q[0] <= wr_val[0];
                    wr_q[1] <= wr_val[1];
                    state   <= ST_WR0;
                end
                ST_WR0:  state <= ST_WR1;
                ST_WR1:  state <= ST_WR2;
                ST_WR2:  state <= ST_WR3;
                ST_WR3:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output update strobe, one cycle after the result is computed.
    always_ff @(posedge clk) begin
        if (!rst_n) echo_valid <= 1'b0;
        else        echo_valid <= (state == ST_CALC);
    end

    // Memory port drive for each state of the frame.
    always_comb begin
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_wdata = 8'h00;
        byte_idx  = 2'd0;
        adv       = 1'b0;
        case (state)
            ST_IDLE: mem_rd_en = frame_strobe;
            ST_RD1:  begin mem_rd_en = 1'b1; byte_idx = 2'd1; end
            ST_RD2:  begin mem_rd_en = 1'b1; byte_idx = 2'd2; end
            ST_RD3:  begin mem_rd_en = 1'b1; byte_idx = 2'd3; end
            ST_WR0:  begin
                mem_wr_en = !echo_wr_dis;
                mem_wdata = wr_q[0][7:0];
            end
            ST_WR1:  begin
                mem_wr_en = !echo_wr_dis;
                mem_wdata = wr_q[0][DW-1:8];
                byte_idx  = 2'd1;
            end
            ST_WR2:  begin
                mem_wr_en = !echo_wr_dis;
                mem_wdata = wr_q[1][7:0];
                byte_idx  = 2'd2;
            end
            ST_WR3:  begin
                mem_wr_en = !echo_wr_dis;
                mem_wdata = wr_q[1][DW-1:8];
                byte_idx  = 2'd3;
                adv       = 1'b1;
            end
            default: ;
        endcase
        mem_addr = frame_addr + AW'(byte_idx);
    end

    // R2
    rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R2
    rd_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> mem_addr == $past(mem_addr) + AW'(1));

    // R2
    wr_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && $past(mem_wr_en)) |-> mem_addr == $past(mem_addr) + AW'(1));

    // R6
    echo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !echo_valid |-> ($stable(echo_l) && $stable(echo_r)));
endmodule

// File: tb/tb_stereo_echo_unit.sv
// Directed bench for the stereo echo unit, with a byte memory model
// covering 0x3000-0x3FFF and an independent frame model built from the requirements.
module tb_stereo_echo_unit;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               frame_strobe = 1'b0;
    logic signed [15:0] mix_l = '0, mix_r = '0;
    logic [7:0]         buf_page;
    logic [3:0]         buf_delay;
    logic [7:0]         fb_gain, vol_l, vol_r;
    logic [63:0]        coef_taps;
    logic               echo_wr_dis;
    logic [15:0]        mem_addr;
    logic               mem_rd_en, mem_wr_en;
    logic [7:0]         mem_wdata;
    logic [7:0]         mem_rdata = 8'h00;
    logic signed [15:0] echo_l, echo_r;
    logic               echo_valid;

    int cfg_page = 8'h34, cfg_dly = 0, cfg_fb = 0, cfg_vl = 0, cfg_vr = 0;
    int cfg_coef [8];
    logic cfg_wrdis = 1'b0;

    int n_cmp = 0, n_bad = 0;
    int n_valid = 0, n_wr = 0, n_rd = 0, n_oob = 0;
    logic [15:0] rd_log [8];

    logic [7:0] mem    [4096];
    logic [7:0] shadow [4096];
    int m_hl [8];
    int m_hr [8];
    int m_ptr = 0;

    always #10 clk = ~clk;

    assign buf_page    = 8'(cfg_page);
    assign buf_delay   = 4'(cfg_dly);
    assign fb_gain     = 8'(cfg_fb);
    assign vol_l       = 8'(cfg_vl);
    assign vol_r       = 8'(cfg_vr);
    assign echo_wr_dis = cfg_wrdis;
    always_comb for (int k = 0; k < 8; k++) coef_taps[k*8 +: 8] = 8'(cfg_coef[k]);

    stereo_echo_unit dut (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
        .mix_l(mix_l), .mix_r(mix_r), .buf_page(buf_page), .buf_delay(buf_delay),
        .fb_gain(fb_gain), .vol_l(vol_l), .vol_r(vol_r), .coef_taps(coef_taps),
        .echo_wr_dis(echo_wr_dis), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .echo_l(echo_l), .echo_r(echo_r), .echo_valid(echo_valid)
    );

    // Synchronous byte memory, read latency one cycle.
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= (mem_addr[15:12] == 4'h3) ? mem[mem_addr[11:0]] : 8'h00;
        if (mem_wr_en && mem_addr[15:12] == 4'h3) mem[mem_addr[11:0]] <= mem_wdata;
    end

    // Port monitor.
    always @(posedge clk) begin
        if (rst_n) begin
            if (echo_valid) n_valid++;
            if (mem_wr_en) n_wr++;
            if (mem_rd_en) begin
                if (n_rd < 8) rd_log[n_rd] = mem_addr;
                n_rd++;
            end
            if ((mem_rd_en || mem_wr_en) && mem_addr[15:12] != 4'h3) n_oob++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int word_at(input int idx, input logic use_shadow);
        logic signed [15:0] w;
        w = use_shadow ? {shadow[idx+1], shadow[idx]} : {mem[idx+1], mem[idx]};
        return int'(w);
    endfunction

    task automatic put_word(input int idx, input int v);
        logic [15:0] w;
        w = 16'(v);
        mem[idx] <= w[7:0];
        mem[idx+1] <= w[15:8];
        shadow[idx] = w[7:0];
        shadow[idx+1] = w[15:8];
    endtask

    task automatic preload(input int seed);
        for (int i = 0; i < 4096; i++) begin
            mem[i] <= 8'((i * 37 + seed) ^ (i >> 3));
            shadow[i] = 8'((i * 37 + seed) ^ (i >> 3));
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        frame_strobe = 1'b0;
        for (int k = 0; k < 8; k++) begin m_hl[k] = 0; m_hr[k] = 0; end
        m_ptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_valid = 0; n_wr = 0; n_rd = 0; n_oob = 0;
        @(negedge clk);
    endtask

    // Requirement model of one frame; returns expected echoes and frame index.
    task automatic model_frame(input int il, input int ir,
                               output int el, output int er, output int fidx);
        int rl, rr, al, ar, fl, fr, len;
        fidx = cfg_page * 256 + m_ptr - 16'h3000;
        rl = word_at(fidx, 1'b1);
        rr = word_at(fidx + 2, 1'b1);
        for (int k = 7; k > 0; k--) begin m_hl[k] = m_hl[k-1]; m_hr[k] = m_hr[k-1]; end
        m_hl[0] = rl;
        m_hr[0] = rr;
        al = 0; ar = 0;
        for (int k = 0; k < 8; k++) begin
            al += cfg_coef[k] * m_hl[k];
            ar += cfg_coef[k] * m_hr[k];
        end
        fl = sat16(al >>> 7);
        fr = sat16(ar >>> 7);
        el = sat16((fl * cfg_vl) >>> 7);
        er = sat16((fr * cfg_vr) >>> 7);
        if (!cfg_wrdis) begin
            logic [15:0] wl, wr;
            wl = 16'(sat16(il + ((fl * cfg_fb) >>> 7)));
            wr = 16'(sat16(ir + ((fr * cfg_fb) >>> 7)));
            shadow[fidx] = wl[7:0];   shadow[fidx+1] = wl[15:8];
            shadow[fidx+2] = wr[7:0]; shadow[fidx+3] = wr[15:8];
        end
        len = (cfg_dly == 0) ? 4 : cfg_dly * 2048;
        m_ptr = (m_ptr + 4 >= len) ? 0 : m_ptr + 4;
    endtask

    // Drive one frame (optionally with a second strobe mid-frame) and compare.
    task automatic run_frame(input string tag, input int il, input int ir, input logic extra);
        int el, er, fidx;
        model_frame(il, ir, el, er, fidx);
        @(negedge clk);
        frame_strobe = 1'b1; mix_l = 16'(il); mix_r = 16'(ir);
        @(negedge clk);
        frame_strobe = 1'b0;
        if (extra) begin
            @(negedge clk);
            frame_strobe = 1'b1;
            @(negedge clk);
            frame_strobe = 1'b0;
        end
        repeat (12) @(negedge clk);
        chk({tag, " R6 echo_l"}, int'(echo_l), el);
        chk({tag, " R6 echo_r"}, int'(echo_r), er);
        chk({tag, " R7 buf left"}, word_at(fidx, 1'b0), word_at(fidx, 1'b1));
        chk({tag, " R7 buf right"}, word_at(fidx + 2, 1'b0), word_at(fidx + 2, 1'b1));
    endtask

    task automatic set_cfg(input int dly, input int fb, input int vl, input int vr, input logic wd);
        cfg_page = 8'h34; cfg_dly = dly; cfg_fb = fb; cfg_vl = vl; cfg_vr = vr; cfg_wrdis = wd;
    endtask

    task automatic t_reset();
        set_cfg(0, 0, 127, 127, 1'b0);
        for (int k = 0; k < 8; k++) cfg_coef[k] = 0;
        preload(1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 echo_l in reset", int'(echo_l), 0);
        chk("R1 mem_rd_en in reset", int'(mem_rd_en), 0);
        do_reset();
        chk("R1 echo_l", int'(echo_l), 0);
        chk("R1 echo_r", int'(echo_r), 0);
        chk("R1 echo_valid", int'(echo_valid), 0);
        chk("R1 mem_wr_en", int'(mem_wr_en), 0);
        repeat (5) @(negedge clk);
        chk("R1 no access without strobe", n_rd + n_wr, 0);
    endtask

    task automatic t_passthrough();
        set_cfg(0, 0, 127, 127, 1'b0);
        cfg_coef[0] = 127;
        for (int k = 1; k < 8; k++) cfg_coef[k] = 0;
        preload(5);
        put_word(16'h0400, 16'h1000);
        put_word(16'h0402, 16'hF000);
        do_reset();
        run_frame("pass f0", 300, -700, 1'b0);
        chk("R5 pass echo_l", int'(echo_l), 4032);
        chk("R5 pass echo_r", int'(echo_r), -4033);
        chk("R2 read order", int'(rd_log[0]), 16'h3400);
        chk("R2 read last byte", int'(rd_log[3]), 16'h3403);
        for (int f = 1; f < 4; f++) run_frame("pass", 1000 * f, -500 * f, 1'b0);
        chk("R3 delay0 single slot", n_oob, 0);
    endtask

    task automatic t_fir_taps();
        set_cfg(0, 0, 100, -90, 1'b0);
        cfg_coef[0] = 64; cfg_coef[1] = 32; cfg_coef[2] = -16; cfg_coef[3] = 8;
        cfg_coef[4] = 0;  cfg_coef[5] = -3; cfg_coef[6] = 0;   cfg_coef[7] = 4;
        preload(9);
        do_reset();
        for (int f = 0; f < 11; f++) run_frame("R4 fir", 2500 * f - 9000, 7000 - 1300 * f, 1'b0);
    endtask

    task automatic t_vol_feedback();
        set_cfg(0, -64, -128, 45, 1'b0);
        cfg_coef[0] = 100; cfg_coef[1] = 20;
        for (int k = 2; k < 8; k++) cfg_coef[k] = 0;
        preload(17);
        do_reset();
        for (int f = 0; f < 6; f++) run_frame("R7 feedback", 4000 - 1500 * f, -2000 + 900 * f, 1'b0);
        cfg_fb = 90;
        for (int f = 0; f < 4; f++) run_frame("R7 feedback pos", 600 * f, -800 * f, 1'b0);
    endtask

    task automatic t_saturation();
        set_cfg(0, 127, 127, 127, 1'b0);
        for (int k = 0; k < 8; k++) cfg_coef[k] = 127;
        preload(3);
        put_word(16'h0400, 16'h7FFF);
        put_word(16'h0402, 16'h8000);
        do_reset();
        run_frame("R9 sat f0", 32767, -32768, 1'b0);
        run_frame("R9 sat f1", 32767, -32768, 1'b0);
        chk("R9 echo_l clamp", int'(echo_l), 32511);
        chk("R9 echo_r clamp", int'(echo_r), -32512);
        chk("R9 write left max", word_at(16'h0400, 1'b0), 32767);
        chk("R9 write right min", word_at(16'h0402, 1'b0), -32768);
    endtask

    task automatic t_wrap_delay();
        set_cfg(1, 0, 127, 127, 1'b0);
        cfg_coef[0] = 127;
        for (int k = 1; k < 8; k++) cfg_coef[k] = 0;
        preload(11);
        do_reset();
        for (int f = 0; f < 515; f++) begin
            run_frame("R3 wrap", 12800 - 20 * f, -256 + 30 * f, 1'b0);
            if (f == 0) chk("R10 written word", word_at(16'h0400, 1'b0), 12800);
            if (f == 512) begin
                chk("R10 echo_l after one lap", int'(echo_l), 12600);
                chk("R10 echo_r after one lap", int'(echo_r), -253);
            end
        end
        chk("R3 accesses stay in buffer", n_oob, 0);
    endtask

    task automatic t_write_disable();
        set_cfg(0, 50, 127, -127, 1'b1);
        cfg_coef[0] = 127; cfg_coef[1] = 64;
        for (int k = 2; k < 8; k++) cfg_coef[k] = 0;
        preload(23);
        put_word(16'h0400, 16'h2000);
        put_word(16'h0402, 16'hE800);
        do_reset();
        for (int f = 0; f < 3; f++) run_frame("R8 wrdis", 9000, -9000, 1'b0);
        chk("R8 no write enable", n_wr, 0);
        chk("R8 left word kept", word_at(16'h0400, 1'b0), 16'h2000);
        chk("R8 right word kept", word_at(16'h0402, 1'b0), -6144);
        chk("R8 reads continue", n_rd, 12);
    endtask

    task automatic t_busy_strobe();
        set_cfg(1, 0, 127, 127, 1'b0);
        cfg_coef[0] = 127;
        for (int k = 1; k < 8; k++) cfg_coef[k] = 0;
        preload(31);
        do_reset();
        run_frame("R2 busy", 1111, -2222, 1'b1);
        chk("R2 one frame per strobe", n_valid, 1);
        chk("R2 four reads", n_rd, 4);
        chk("R2 four writes", n_wr, 4);
        run_frame("R2 next slot", 3333, -4444, 1'b0);
        chk("R2 second frame address", int'(rd_log[4]), 16'h3404);
    endtask

    initial begin
        t_reset();
        t_passthrough();
        t_fir_taps();
        t_vol_feedback();
        t_saturation();
        t_wrap_delay();
        t_write_disable();
        t_busy_strobe();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule